// File: doc/BRIEF.md
# Periodic SAR Converter Scheduler

This block sequences an 8-bit successive-approximation converter that has three analog inputs. A two-bit select field either switches the converter off or picks one input. When the converter is switched on, the block waits out a start-up interval and then starts conversions at a fixed period. Each conversion tests one bit per clock. The block drives the trial code to an external DAC and reads back one comparator bit.

Finished codes go to a result register. A predictive status flag tells the host when that register may change. When the flag is low, no write will happen for at least a guard interval, so the host can read safely. A read started from the serial interface locks the register. A conversion that finishes during the lock is parked in a shadow register and copied over once the lock ends. The lock ends when the read completes or when chip select drops.

Top module: `adc_sched`

## Requirements
- R1: While reset is held, and right after it, `result`, `dac` and `mux_sel` are zero and `cu` is 0.
- R2: With `sel` = 00 the converter is off. From the next clock on, `cu` is 0 and `dac` is 0, and `result` keeps its value. Switching off abandons any conversion in progress and discards a parked value.
- R3: `sel` = 01, 10 and 11 select input 0, 1 and 2. `mux_sel` carries the input number (0, 1 or 2) and never shows 3.
- R4: A conversion tests bit W-1 down to bit 0, one bit per clock. The first trial code is 1 followed by zeros. A bit is kept when `cmp` is 1, meaning the input is at or above the trial code. A full-scale input yields FFh and ground yields 00h.
- R5: The first clock edge that samples a nonzero `sel` while the converter is off starts the countdown. The first result appears after edge START_CYC+W+1, counting that edge as 1.
- R6: After the first conversion, conversions start every PERIOD_CYC clocks.
- R7: A change of `sel` while the converter is on does not touch the conversion under way or `mux_sel`. The new input is used from the next conversion start.
- R8: `cu` rises during start-up once fewer than GUARD_CYC countdown cycles remain. It stays 1 while the converter is on from then. `result` changes only after a cycle with `cu` = 1, and never within GUARD_CYC cycles of `cu` rising.
- R9: A `rd_start` pulse while `cs` is 1 locks `result`. No write reaches it while locked. `rd_start` with `cs` at 0 is ignored.
- R10: The lock ends on the edge that samples `rd_done` = 1 or `cs` = 0. A parked value appears in `result` one edge later.
- R11: When several conversions finish during one lock, the parked value is the newest one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 2 | Input select; 00 turns the converter off |
| cmp | input | 1 | Comparator: 1 when the input is at or above `dac` |
| rd_start | input | 1 | Host read of the result register begins |
| rd_done | input | 1 | Host read of the result register completes |
| cs | input | 1 | Serial chip select, active high |
| dac | output | W | Trial code during a conversion, else 0 |
| mux_sel | output | 2 | Analog input number in use |
| result | output | W | Last converted code |
| cu | output | 1 | Update-pending flag |

## Verification
The assertions watch every cycle for these properties:
- Writes to `result` happen only after `cu` was high, and never inside the guard window after `cu` rises.
- No write lands while the read lock is held.
- An off select silences `dac` and `cu`.
- Each conversion opens with the MSB trial.
- `mux_sel` moves only at a conversion start and never takes the unused code.

Only the bench scenarios can show the rest:
- the converted code values across inputs and channels;
- the exact start-up latency and conversion period;
- the parked value that appears after a read completes or chip select drops, and that it is the newest one.

// File: rtl/adc_sched.sv
module adc_sched #(
  parameter int W          = 8,
  parameter int START_CYC  = 120,
  parameter int PERIOD_CYC = 20,
  parameter int GUARD_CYC  = 60
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   sel,
  input  logic         cmp,
  input  logic         rd_start,
  input  logic         rd_done,
  input  logic         cs,
  output logic [W-1:0] dac,
  output logic [1:0]   mux_sel,
  output logic [W-1:0] result,
  output logic         cu
);
  localparam int TW = $clog2(START_CYC + 1);
  localparam int IW = (W > 1) ? $clog2(W) : 1;

  logic          on, primed, conv, lock_q, pend;
  logic [IW-1:0] idx;
  logic [W-1:0]  sar, shadow;
  logic [TW-1:0] tmr;
  logic [W-1:0]  trial, code;
  logic          done;

  assign trial = sar | (W'(1) << idx);
  assign dac   = conv ? trial : '0;
  assign done  = conv && (idx == '0);
  assign code  = cmp ? trial : sar;
  assign cu    = on && (primed || (tmr < TW'(GUARD_CYC)));

  always_ff @(posedge clk) begin
    if (!rst_n)                lock_q <= 1'b0;
    else if (!cs || rd_done)   lock_q <= 1'b0;
    else if (rd_start)         lock_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on <= 1'b0; primed <= 1'b0; conv <= 1'b0; pend <= 1'b0;
      idx <= '0; sar <= '0; shadow <= '0; tmr <= '0;
      result <= '0; mux_sel <= '0;
    end else if (sel == 2'b00) begin
      on <= 1'b0; primed <= 1'b0; conv <= 1'b0; pend <= 1'b0; tmr <= '0;
    end else begin
      if (!on) begin
        on  <= 1'b1;
        tmr <= TW'(START_CYC - 1);
      end else if (tmr == '0) begin
        tmr     <= TW'(PERIOD_CYC - 1);
        conv    <= 1'b1;
        idx     <= IW'(W - 1);
        sar     <= '0;
        mux_sel <= sel - 2'd1;
        primed  <= 1'b1;
      end else begin
        tmr <= tmr - 1'b1;
      end

      if (conv) begin
        if (cmp) sar <= trial;
        if (idx == '0) conv <= 1'b0;
        else           idx  <= idx - 1'b1;
      end

      if (done) begin
        if (lock_q) begin
          shadow <= code;
          pend   <= 1'b1;
        end else begin
          result <= code;
          pend   <= 1'b0;
        end
      end else if (pend && !lock_q) begin
        result <= shadow;
        pend   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_sched_chk.sv
module adc_sched_chk #(
  parameter int W         = 8,
  parameter int GUARD_CYC = 60
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   sel,
  input logic [W-1:0] dac,
  input logic [1:0]   mux_sel,
  input logic [W-1:0] result,
  input logic         cu,
  input logic         lock_q
);
  localparam int CW = $clog2(GUARD_CYC + 1);
  logic          cu_d;
  logic [CW-1:0] since_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cu_d       <= 1'b0;
      since_rise <= '0;
    end else begin
      cu_d <= cu;
      if (cu && !cu_d)                        since_rise <= CW'(1);
      else if (since_rise < CW'(GUARD_CYC))   since_rise <= since_rise + 1'b1;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (result == '0 && cu == 1'b0 && dac == '0 && mux_sel == 2'd0));

  a_r2_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b00) |=> (cu == 1'b0 && dac == '0));

  a_r3_no_unused_input: assert property (@(posedge clk) disable iff (!rst_n)
    mux_sel != 2'd3);

  a_r4_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac != '0) |-> (dac == {1'b1, {(W-1){1'b0}}}));

  a_r7_mux_moves_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mux_sel) |-> (dac == {1'b1, {(W-1){1'b0}}}));

  a_r8_write_after_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $past(cu));

  a_r8_guard_window: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> (since_rise >= CW'(GUARD_CYC)));

  a_r9_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> !$past(lock_q));
endmodule

bind adc_sched adc_sched_chk #(.W(W), .GUARD_CYC(GUARD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .dac(dac), .mux_sel(mux_sel),
  .result(result), .cu(cu), .lock_q(lock_q)
);

// File: tb/sim_adc_sched.sv
`timescale 1ns/1ps
module sim_adc_sched;
  localparam int W = 8, START = 120, PER = 20, GUARD = 60;

  logic clk = 1'b0;
  logic rst_n, cs, rd_start, rd_done, cmp, cu;
  logic [1:0] sel, mux_sel;
  logic [W-1:0] dac, result;
  logic [W-1:0] ain [3];
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign cmp = (ain[mux_sel] >= dac);

  adc_sched #(.W(W), .START_CYC(START), .PERIOD_CYC(PER), .GUARD_CYC(GUARD)) u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .cmp(cmp), .rd_start(rd_start),
    .rd_done(rd_done), .cs(cs), .dac(dac), .mux_sel(mux_sel),
    .result(result), .cu(cu)
  );

  // {sel, input level, expected code, expected mux_sel}
  localparam logic [19:0] VEC [8] = '{
    {2'b01, 8'h00, 8'h00, 2'd0}, {2'b01, 8'hFF, 8'hFF, 2'd0},
    {2'b10, 8'h80, 8'h80, 2'd1}, {2'b10, 8'h7F, 8'h7F, 2'd1},
    {2'b11, 8'h01, 8'h01, 2'd2}, {2'b11, 8'hFE, 8'hFE, 2'd2},
    {2'b01, 8'h5A, 8'h5A, 2'd0}, {2'b11, 8'hC3, 8'hC3, 2'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_rise(output int n);
    logic [W-1:0] prev;
    n = 0;
    prev = dac;
    for (int k = 0; k < 1000; k++) begin
      @(posedge clk); #1;
      n++;
      if (prev == '0 && dac != '0) return;
      prev = dac;
    end
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  task automatic startup_latency(input string req);
    int n;
    logic [W-1:0] old;
    old = result;
    n = 0;
    for (int k = 0; k < 1000; k++) begin
      @(posedge clk); #1;
      n++;
      if (n == 1) chk({req, " R8 cu low at start"}, cu, 0);
      if (n == START - GUARD) chk("R8 cu low before guard", cu, 0);
      if (n == START - GUARD + 1) chk("R8 cu rises in guard", cu, 1);
      if (result != old) break;
    end
    chk({req, " first result latency"}, n, START + W + 1);
  endtask

  initial begin
    int n;
    rst_n = 1'b0; sel = 2'b00; cs = 1'b1; rd_start = 1'b0; rd_done = 1'b0;
    ain[0] = '0; ain[1] = '0; ain[2] = '0;
    edges(3);
    chk("R1 result", result, 0); chk("R1 cu", cu, 0);
    chk("R1 dac", dac, 0);       chk("R1 mux_sel", mux_sel, 0);
    @(negedge clk); rst_n = 1'b1;

    // R5 / R8 start-up timing
    @(negedge clk); ain[0] = 8'hA5; sel = 2'b01;
    startup_latency("R5");
    chk("R4 code A5", result, 8'hA5);

    // R6 period
    wait_rise(n);
    wait_rise(n);
    chk("R6 period", n, PER);

    // R7 change takes effect at next slot
    edges(W + 2);
    @(negedge clk); ain[1] = 8'h3C; sel = 2'b10;
    @(posedge clk); #1;
    chk("R7 mux_sel held", mux_sel, 0);
    wait_rise(n);
    chk("R7 mux_sel at next start", mux_sel, 1);
    edges(W + 2);
    chk("R7 new channel code", result, 8'h3C);

    // R3 / R4 vector table
    foreach (VEC[i]) begin
      @(negedge clk);
      for (int c = 0; c < 3; c++) ain[c] = ~VEC[i][17:10];
      ain[VEC[i][19:18] - 2'd1] = VEC[i][17:10];
      sel = VEC[i][19:18];
      edges(2 * PER + W + 2);
      chk("R4 vector code", result, VEC[i][9:2]);
      chk("R3 vector mux_sel", mux_sel, VEC[i][1:0]);
    end

    // R9 / R10 / R11 lock and release by read completion
    @(negedge clk); sel = 2'b01; ain[0] = 8'h11;
    edges(3 * PER);
    chk("R9 pre-lock code", result, 8'h11);
    @(negedge clk); rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0; ain[0] = 8'h22;
    edges(2 * PER);
    @(negedge clk); ain[0] = 8'h33;
    edges(2 * PER);
    chk("R9 held under lock", result, 8'h11);
    @(negedge clk); rd_done = 1'b1;
    @(posedge clk); #1;
    chk("R10 not yet written", result, 8'h11);
    @(negedge clk); rd_done = 1'b0;
    @(posedge clk); #1;
    chk("R11 newest parked value", result, 8'h33);

    // R10 release by chip select
    @(negedge clk); ain[0] = 8'h44;
    edges(2 * PER);
    chk("R10 pre-lock code", result, 8'h44);
    @(negedge clk); rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0; ain[0] = 8'h55;
    edges(2 * PER);
    chk("R9 held under lock cs", result, 8'h44);
    @(negedge clk); cs = 1'b0;
    @(posedge clk); #1;
    chk("R10 cs edge no write yet", result, 8'h44);
    @(negedge clk); cs = 1'b1;
    @(posedge clk); #1;
    chk("R10 cs abort writes", result, 8'h55);

    // R9 start with cs low ignored
    @(negedge clk); cs = 1'b0; rd_start = 1'b1;
    @(negedge clk); cs = 1'b1; rd_start = 1'b0; ain[0] = 8'h66;
    edges(2 * PER + W);
    chk("R9 no lock without cs", result, 8'h66);

    // R2 off
    @(negedge clk); sel = 2'b00;
    @(posedge clk); #1;
    chk("R2 cu off", cu, 0);
    ain[0] = 8'h77;
    begin
      int busy = 0;
      for (int k = 0; k < 3 * PER; k++) begin
        @(posedge clk); #1;
        if (dac != '0 || cu) busy++;
      end
      chk("R2 quiet while off", busy, 0);
    end
    chk("R2 result held", result, 8'h66);
    chk("R2 mux_sel held", mux_sel, 0);

    // R5 again after re-enable on input 2
    @(negedge clk); ain[2] = 8'h99; sel = 2'b11;
    startup_latency("R5 re-enable");
    chk("R3 input 2 code", result, 8'h99);
    chk("R3 input 2 mux_sel", mux_sel, 2);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule